// File: doc/BRIEF.md
# Serial Peripheral Shifter with Switchable Word Queues

This block moves words between a register bus and a four-wire synchronous serial link. It can act as the clock-driving master or as a clocked slave. Each word is 8 or 16 bits, sent most significant bit first. The outgoing bit changes while the serial clock is low and the incoming bit is captured on the rising clock edge. The select line stays low for the whole word.

Software picks one of two buffering schemes. In the single-word scheme each direction holds one word. In the queued scheme each direction holds up to eight words. The status word reports full and empty states, an overflow, whether the shifter has drained, and a 3-bit receive occupancy count. One interrupt line follows whichever buffer condition is chosen in the control word.

Top module: `spi_efifo`

## Requirements
- R1: After reset the control word reads 0x0000, the status word reads 0x002C (receive empty, shifter idle, transmit empty) and `irq` is low.
- R2: In master mode (control bit0=1 enable, bit1=1 master), a queued transmit word is shifted out on `sdo` most significant bit first. `sdo` is stable at every rising `sck_o`. `sdi` is captured at each rising `sck_o` into the received word. `ss_n_o` is low whenever `sck_o` is high.
- R3: Control bit2 selects a 16-bit word (1) or an 8-bit word (0). An 8-bit word sends the low byte of the written value in 8 clocks and is received with its upper byte zero.
- R4: With control bit3=0 (single-word scheme), each direction holds one word. A second transmit write while one word is held is ignored, and receive-full (status bit1) sets once one word is held.
- R5: With control bit3=1 (queued scheme), transmit-full (status bit0) sets only when eight words are held. A ninth write is ignored.
- R6: Status bits 10:8 give the receive occupancy modulo 8. With eight words held they read 0 and status bit1 is set.
- R7: A received word that finds the receive side full is discarded and sets the sticky overflow flag (status bit4). Writing the status address with bit4=1 clears the flag. Writing it with bit4=0 leaves the flag set.
- R8: Reading the data address (0) pops the oldest received word. When the receive side is empty the read returns 0 and changes nothing.
- R9: Status bit3 is set exactly when no word is being shifted and the transmit side is empty. Status bit5 is transmit-empty and status bit2 is receive-empty.
- R10: Control bits 6:4 select the interrupt condition: 0 never, 1 receive not empty, 2 receive holds at least 6, 3 receive full, 4 transmit not full, 5 transmit empty, 6 transmit full, 7 shifter idle with transmit empty.
- R11: The serial half period is (S+1)·4^P system clocks, with P in control bits 9:8 and S in control bits 12:10. A control write with P=3 and S=7 together is ignored entirely.
- R12: In slave mode (bit1=0), while `ss_n_i` is low, the block shifts the oldest transmit word out on `sdo` (zero if none is held), captures `sdi` on rising `sck_i`, and queues the received word.
- R13: Words leave each queue in the order they were written or received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on data address) |
| bus_addr | input | 2 | 0 data, 1 control, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| ss_n_o | output | 1 | Select driven in master mode, active low |
| ss_n_i | input | 1 | Select received in slave mode, active low |
| irq | output | 1 | Selected buffer condition |

## Verification
The bench fills the transmit queue to exactly eight words and then attempts a ninth. A queue that reported full one word early or accepted the extra word would show the wrong flag or return an extra word on readback. It lets a word arrive on a full receive queue. A design that overwrote instead of discarding would return that word, and one without a sticky flag would lose the overflow. It also checks the occupancy field wrapping to 0 at eight, the empty-read value, each interrupt code at its threshold, the rejected prescaler pair, and a serial word order checked by an independent monitor on the pins. That monitor exposes a reversed bit order or a clock edge placed in the wrong phase.

// File: rtl/spi_efifo_pkg.sv
package spi_efifo_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ADR_DATA = 2'd0,
        ADR_CTRL = 2'd1,
        ADR_STAT = 2'd2,
        ADR_NONE = 2'd3
    } addr_e;

    typedef enum logic [2:0] {
        IRQ_OFF      = 3'd0,
        IRQ_RX_ANY   = 3'd1,
        IRQ_RX_HIGH  = 3'd2,
        IRQ_RX_FULL  = 3'd3,
        IRQ_TX_ROOM  = 3'd4,
        IRQ_TX_EMPTY = 3'd5,
        IRQ_TX_FULL  = 3'd6,
        IRQ_DRAINED  = 3'd7
    } irq_sel_e;

    typedef struct packed {
        logic [2:0] sec;
        logic [1:0] pri;
        irq_sel_e   irq;
        logic       enh;
        logic       wide;
        logic       master;
        logic       en;
    } cfg_t;

    typedef struct packed {
        logic       tx_full;
        logic       rx_full;
        logic       rx_empty;
        logic       idle;
        logic       ovf;
        logic       tx_empty;
        logic [2:0] rx_cnt;
    } stat_t;

    function automatic cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.en     = w[0];
        c.master = w[1];
        c.wide   = w[2];
        c.enh    = w[3];
        c.irq    = irq_sel_e'(w[6:4]);
        c.pri    = w[9:8];
        c.sec    = w[12:10];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
        return {3'b000, c.sec, c.pri, 1'b0, c.irq, c.enh, c.wide, c.master, c.en};
    endfunction

    function automatic logic [WORD_W-1:0] stat_to_word(input stat_t s);
        return {5'b00000, s.rx_cnt, 2'b00, s.tx_empty, s.ovf, s.idle,
                s.rx_empty, s.rx_full, s.tx_full};
    endfunction

    function automatic logic rate_forbidden(input logic [1:0] pri, input logic [2:0] sec);
        return (pri == 2'd3) && (sec == 3'd7);
    endfunction

    function automatic logic [9:0] half_period(input logic [1:0] pri, input logic [2:0] sec);
        logic [9:0] base;
        base = {7'd0, sec} + 10'd1;
        return base << (2 * pri);
    endfunction

    function automatic logic [WORD_W-1:0] align_tx(input logic [WORD_W-1:0] w, input logic wide);
        return wide ? w : {w[7:0], 8'h00};
    endfunction

    function automatic logic [WORD_W-1:0] trim_rx(input logic [WORD_W-1:0] w, input logic wide);
        return wide ? w : {8'h00, w[7:0]};
    endfunction

endpackage

// File: rtl/spi_efifo_fifo.sv
module spi_efifo_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty,
    output logic          drop
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          do_push, do_pop;

    assign limit   = single ? CW'(1) : CW'(DEPTH);
    assign full    = (cnt_q >= limit);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign dout    = mem[rp];
    assign cnt     = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/spi_efifo_shifter.sv
module spi_efifo_shifter
    import spi_efifo_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic [WORD_W-1:0] tx_head,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              busy,
    output logic              sck_o,
    output logic              sdo,
    output logic              ss_n_o,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              sdi
);

    logic [WORD_W-1:0] sh_tx, sh_rx;
    logic [3:0]        bitcnt, last;
    logic [9:0]        div, half;
    logic              sck_q, mbusy;
    logic [SS:0]       s_sck;
    logic [SS-1:0]     s_ss, s_sdi;
    logic              sloaded, sfresh;
    logic              m_sel, s_sel, m_start, m_tick;
    logic              s_rise, s_fall, s_act, s_load, in_bit;

    assign last    = cfg.wide ? 4'd15 : 4'd7;
    assign half    = half_period(cfg.pri, cfg.sec);
    assign m_sel   = cfg.en && cfg.master;
    assign s_sel   = cfg.en && !cfg.master;
    assign m_start = m_sel && !mbusy && !tx_empty;
    assign m_tick  = mbusy && (div == half - 10'd1);

    assign s_rise  = s_sck[SS-1] && !s_sck[SS];
    assign s_fall  = !s_sck[SS-1] && s_sck[SS];
    assign s_act   = s_sel && !s_ss[SS-1];
    assign s_load  = s_act && !sloaded;

    assign in_bit  = cfg.master ? sdi : s_sdi[SS-1];
    assign tx_pop  = m_start || (s_load && !tx_empty);
    assign rx_push = (m_sel && m_tick && !sck_q && (bitcnt == last)) ||
                     (s_act && sloaded && s_rise && (bitcnt == last));
    assign rx_word = trim_rx({sh_rx[WORD_W-2:0], in_bit}, cfg.wide);

    assign busy    = mbusy || s_act;
    assign sck_o   = sck_q;
    assign sdo     = sh_tx[WORD_W-1];
    assign ss_n_o  = !mbusy;

    // input synchronisers for the slave-side pins
    always_ff @(posedge clk) begin
        if (rst) begin
            s_sck <= '0;
            s_ss  <= '1;
            s_sdi <= '0;
        end else begin
            s_sck <= {s_sck[SS-1:0], sck_i};
            s_ss  <= {s_ss[SS-2:0], ss_n_i};
            s_sdi <= {s_sdi[SS-2:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_tx   <= '0;
            sh_rx   <= '0;
            bitcnt  <= '0;
            div     <= '0;
            sck_q   <= 1'b0;
            mbusy   <= 1'b0;
            sloaded <= 1'b0;
            sfresh  <= 1'b0;
        end else if (!cfg.en) begin
            mbusy   <= 1'b0;
            sck_q   <= 1'b0;
            sloaded <= 1'b0;
            bitcnt  <= '0;
            div     <= '0;
        end else if (cfg.master) begin
            sloaded <= 1'b0;
            if (m_start) begin
                mbusy  <= 1'b1;
                sh_tx  <= align_tx(tx_head, cfg.wide);
                bitcnt <= '0;
                div    <= '0;
                sck_q  <= 1'b0;
            end else if (mbusy) begin
                if (m_tick) begin
                    div <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        sh_rx <= {sh_rx[WORD_W-2:0], sdi};
                    end else begin
                        sck_q <= 1'b0;
                        if (bitcnt == last) begin
                            mbusy <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            sh_tx  <= {sh_tx[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    div <= div + 10'd1;
                end
            end
        end else begin
            mbusy <= 1'b0;
            sck_q <= 1'b0;
            if (!s_act) begin
                sloaded <= 1'b0;
                bitcnt  <= '0;
            end else if (s_load) begin
                sh_tx   <= tx_empty ? '0 : align_tx(tx_head, cfg.wide);
                sloaded <= 1'b1;
                sfresh  <= 1'b1;
                bitcnt  <= '0;
            end else if (s_rise) begin
                sh_rx  <= {sh_rx[WORD_W-2:0], s_sdi[SS-1]};
                sfresh <= 1'b0;
                if (bitcnt == last) begin
                    bitcnt  <= '0;
                    sloaded <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 4'd1;
                end
            end else if (s_fall && !sfresh) begin
                sh_tx <= {sh_tx[WORD_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_efifo.sv
module spi_efifo
    import spi_efifo_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int RX_HIGH = 6,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        sck_o,
    input  logic        sck_i,
    output logic        sdo,
    input  logic        sdi,
    output logic        ss_n_o,
    input  logic        ss_n_i,
    output logic        irq
);

    cfg_t              ctrl_q;
    logic              ovf_q;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_drop, rx_drop;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              tx_pop, rx_push, busy;
    logic              wr_data, wr_ctrl, wr_stat, rd_data;
    logic [15:0]       ctrl_word;
    logic [2:0]        irq_sel;
    stat_t             stat;

    assign wr_data   = bus_wr && (addr_e'(bus_addr) == ADR_DATA);
    assign wr_ctrl   = bus_wr && (addr_e'(bus_addr) == ADR_CTRL);
    assign wr_stat   = bus_wr && (addr_e'(bus_addr) == ADR_STAT);
    assign rd_data   = bus_rd && (addr_e'(bus_addr) == ADR_DATA);
    assign ctrl_word = cfg_to_word(ctrl_q);
    assign irq_sel   = ctrl_q.irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= cfg_from_word('0);
            ovf_q  <= 1'b0;
        end else begin
            if (wr_ctrl && !rate_forbidden(bus_wdata[9:8], bus_wdata[12:10]))
                ctrl_q <= cfg_from_word(bus_wdata);
            if (rx_drop)
                ovf_q <= 1'b1;
            else if (wr_stat && bus_wdata[4])
                ovf_q <= 1'b0;
        end
    end

    spi_efifo_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .single(!ctrl_q.enh),
        .push  (wr_data),
        .din   (bus_wdata),
        .pop   (tx_pop),
        .dout  (tx_head),
        .cnt   (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty),
        .drop  (tx_drop)
    );

    spi_efifo_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .single(!ctrl_q.enh),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (rd_data),
        .dout  (rx_head),
        .cnt   (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty),
        .drop  (rx_drop)
    );

    spi_efifo_shifter #(.SYNC_STAGES(2)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .cfg     (ctrl_q),
        .tx_head (tx_head),
        .tx_empty(tx_empty),
        .tx_pop  (tx_pop),
        .rx_push (rx_push),
        .rx_word (rx_word),
        .busy    (busy),
        .sck_o   (sck_o),
        .sdo     (sdo),
        .ss_n_o  (ss_n_o),
        .sck_i   (sck_i),
        .ss_n_i  (ss_n_i),
        .sdi     (sdi)
    );

    always_comb begin
        stat.tx_full  = tx_full;
        stat.rx_full  = rx_full;
        stat.rx_empty = rx_empty;
        stat.idle     = !busy && tx_empty;
        stat.ovf      = ovf_q;
        stat.tx_empty = tx_empty;
        stat.rx_cnt   = rx_cnt[2:0];
    end

    always_comb begin
        case (addr_e'(bus_addr))
            ADR_DATA: bus_rdata = rx_empty ? '0 : rx_head;
            ADR_CTRL: bus_rdata = ctrl_word;
            ADR_STAT: bus_rdata = stat_to_word(stat);
            default:  bus_rdata = '0;
        endcase
    end

    always_comb begin
        case (ctrl_q.irq)
            IRQ_RX_ANY:   irq = !rx_empty;
            IRQ_RX_HIGH:  irq = (rx_cnt >= CW'(RX_HIGH));
            IRQ_RX_FULL:  irq = rx_full;
            IRQ_TX_ROOM:  irq = !tx_full;
            IRQ_TX_EMPTY: irq = tx_empty;
            IRQ_TX_FULL:  irq = tx_full;
            IRQ_DRAINED:  irq = !busy && tx_empty;
            default:      irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_efifo_chk.sv
module spi_efifo_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic [15:0]   bus_wdata,
    input logic          sck_o,
    input logic          ss_n_o,
    input logic          irq,
    input logic [2:0]    irq_sel,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic          ovf_q,
    input logic          rx_push,
    input logic [15:0]   ctrl_word
);

    // R2: the clock only toggles high inside a selected frame
    a_r2_sck_in_frame: assert property (@(posedge clk) disable iff (rst)
        sck_o |-> !ss_n_o);

    // R5: transmit occupancy never exceeds the queue depth
    a_r5_tx_bound: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= CW'(DEPTH));

    // R7: receive occupancy never exceeds the queue depth
    a_r7_rx_bound: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CW'(DEPTH));

    // R7: a push onto a completely full receive queue raises the flag
    a_r7_ovf_on_drop: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_cnt == CW'(DEPTH)) |=> ovf_q);

    // R7: the flag holds until software clears it
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(bus_wr && bus_addr == 2'd2 && bus_wdata[4])) |=> ovf_q);

    // R11: the forbidden prescaler pair leaves control untouched
    a_r11_reject_rate: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1 && bus_wdata[9:8] == 2'b11 && bus_wdata[12:10] == 3'b111)
        |=> $stable(ctrl_word));

    // R10: code 0 keeps the interrupt quiet
    a_r10_irq_off: assert property (@(posedge clk) disable iff (rst)
        (irq_sel == 3'd0) |-> !irq);

endmodule

bind spi_efifo spi_efifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sck_o    (sck_o),
    .ss_n_o   (ss_n_o),
    .irq      (irq),
    .irq_sel  (irq_sel),
    .tx_cnt   (tx_cnt),
    .rx_cnt   (rx_cnt),
    .ovf_q    (ovf_q),
    .rx_push  (rx_push),
    .ctrl_word(ctrl_word)
);

// File: tb/spi_efifo_tb.sv
module spi_efifo_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        sck_o, sdo, ss_n_o, irq;
    logic        sck_i = 1'b0, ss_n_i = 1'b1, sdi;
    logic        tb_slave = 1'b0, inv = 1'b0, tb_sdi = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_rise = 0;
    int rise_gap = 0;
    int mon_bits = 0;
    logic [15:0] mon_word = 16'd0;

    always #2.5 clk = ~clk;

    assign sdi = tb_slave ? tb_sdi : (sdo ^ inv);

    spi_efifo u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .sck_i(sck_i), .sdo(sdo), .sdi(sdi),
        .ss_n_o(ss_n_o), .ss_n_i(ss_n_i), .irq(irq)
    );

    always @(negedge clk) cyc <= cyc + 1;

    // pin monitor: captures the word seen on sdo at each rising serial clock
    always @(posedge sck_o) begin
        mon_word  <= {mon_word[14:0], sdo};
        mon_bits  <= mon_bits + 1;
        rise_gap  <= cyc - last_rise;
        last_rise <= cyc;
    end

    function automatic logic [15:0] cw(input logic en, input logic m, input logic w,
                                       input logic e, input logic [2:0] q,
                                       input logic [1:0] p, input logic [2:0] s);
        return {3'b000, s, p, 1'b0, q, e, w, m, en};
    endfunction

    function automatic logic [15:0] sw(input logic txf, input logic rxf, input logic rxe,
                                       input logic idl, input logic ov, input logic txe,
                                       input logic [2:0] c);
        return {5'b00000, c, 2'b00, txe, ov, idl, rxe, rxf, txf};
    endfunction

    function automatic logic [15:0] exp_rx(input logic [15:0] t, input logic w, input logic iv);
        logic [15:0] v;
        v = iv ? ~t : t;
        return w ? v : {8'h00, v[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(2'd2, s);
            if (s[3]) break;
        end
    endtask

    task automatic master_word(input string tag, input logic [15:0] t, input logic w,
                               input logic iv);
        logic [15:0] r;
        int b0;
        inv = iv;
        bus_write(2'd1, cw(1, 1, w, 1, 3'd0, 2'd0, 3'd0));
        b0 = mon_bits;
        bus_write(2'd0, t);
        wait_idle();
        chk({tag, " R3 clock count"}, mon_bits - b0, w ? 16 : 8);
        chk({tag, " R2 pin order"}, w ? mon_word : {8'h00, mon_word[7:0]},
            w ? t : {8'h00, t[7:0]});
        bus_read(2'd0, r);
        chk({tag, " R2 received"}, r, exp_rx(t, w, iv));
        inv = 1'b0;
    endtask

    task automatic slave_word(input logic [15:0] mo, output logic [15:0] mi);
        ss_n_i = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 15; i >= 0; i--) begin
            tb_sdi = mo[i];
            repeat (6) @(negedge clk);
            mi[i] = sdo;
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (10) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [15:0] words [8];
        logic [15:0] t;
        logic w, iv;
        void'($urandom(32'h5A17));

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(2'd1, r);
        chk("R1 control", r, 16'h0000);
        bus_read(2'd2, r);
        chk("R1 status", r, 16'h002C);
        chk("R1 irq", irq, 0);

        // R8 empty read
        bus_read(2'd0, r);
        chk("R8 empty read", r, 16'h0000);
        bus_read(2'd2, r);
        chk("R8 status after empty read", r, 16'h002C);

        // R2 / R3 directed words
        master_word("R2 dir a55a", 16'hA55A, 1, 0);
        chk("R11 default half period", rise_gap, 2);
        master_word("R2 inverted", 16'h1234, 1, 1);
        master_word("R3 narrow", 16'h1F3C, 0, 0);
        master_word("R3 narrow inv", 16'h80C1, 0, 1);

        // randomized words
        for (int k = 0; k < 16; k++) begin
            t  = 16'($urandom);
            w  = 1'($urandom);
            iv = 1'($urandom);
            master_word("R2 random", t, w, iv);
        end

        // R11 prescaler: P=1, S=1 -> half period 8 clocks
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd0, 2'd1, 3'd1));
        bus_write(2'd0, 16'h0F0F);
        wait_idle();
        chk("R11 period P1 S1", rise_gap, 16);
        bus_read(2'd0, r);
        chk("R11 slow word", r, 16'h0F0F);
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd0, 2'd2, 3'd0));
        bus_write(2'd0, 16'h00FF);
        wait_idle();
        chk("R11 period P2 S0", rise_gap, 32);
        bus_read(2'd0, r);
        bus_write(2'd1, cw(1, 0, 0, 0, 3'd5, 2'd3, 3'd7));
        bus_read(2'd1, r);
        chk("R11 forbidden pair ignored", r, cw(1, 1, 1, 1, 3'd0, 2'd2, 3'd0));

        // R5 / R10 fill the transmit queue while disabled
        bus_write(2'd1, cw(0, 1, 1, 1, 3'd6, 2'd0, 3'd0));
        for (int i = 0; i < 8; i++) words[i] = 16'h3000 + 16'(i * 16'h0111);
        for (int i = 0; i < 7; i++) bus_write(2'd0, words[i]);
        bus_read(2'd2, r);
        chk("R5 not full at seven", r[0], 0);
        chk("R10 tx full irq at seven", irq, 0);
        bus_write(2'd0, words[7]);
        bus_read(2'd2, r);
        chk("R5 full at eight", r[0], 1);
        chk("R10 tx full irq at eight", irq, 1);
        bus_write(2'd0, 16'hBAD0);
        bus_write(2'd1, cw(0, 1, 1, 1, 3'd5, 2'd0, 3'd0));
        chk("R10 tx empty irq", irq, 0);
        bus_write(2'd1, cw(0, 1, 1, 1, 3'd4, 2'd0, 3'd0));
        chk("R10 tx room irq", irq, 0);

        // drain into the receive queue
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd3, 2'd0, 3'd0));
        wait_idle();
        chk("R10 rx full irq", irq, 1);
        bus_read(2'd2, r);
        chk("R6 status at eight", r, sw(0, 1, 0, 1, 0, 1, 3'd0));
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd2, 2'd0, 3'd0));
        chk("R10 rx high irq at eight", irq, 1);
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd1, 2'd0, 3'd0));
        chk("R10 rx any irq", irq, 1);
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd4, 2'd0, 3'd0));
        chk("R10 tx room irq empty", irq, 1);

        // R7 overflow
        bus_write(2'd0, 16'hDEAD);
        wait_idle();
        bus_read(2'd2, r);
        chk("R7 overflow set", r, sw(0, 1, 0, 1, 1, 1, 3'd0));
        bus_write(2'd2, 16'h0000);
        bus_read(2'd2, r);
        chk("R7 overflow sticky", r[4], 1);

        // R13 order, R6 count
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd2, 2'd0, 3'd0));
        for (int i = 0; i < 3; i++) begin
            bus_read(2'd0, r);
            chk("R13 order", r, words[i]);
        end
        bus_read(2'd2, r);
        chk("R6 count after three reads", r[10:8], 3'd5);
        chk("R10 rx high irq at five", irq, 0);
        for (int i = 3; i < 8; i++) begin
            bus_read(2'd0, r);
            chk("R13 order", r, words[i]);
        end
        bus_read(2'd0, r);
        chk("R7 dropped word absent", r, 16'h0000);
        bus_write(2'd2, 16'h0010);
        bus_read(2'd2, r);
        chk("R7 cleared, R9 idle", r, sw(0, 0, 1, 1, 0, 1, 3'd0));
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd7, 2'd0, 3'd0));
        chk("R10 drained irq", irq, 1);
        bus_write(2'd1, cw(1, 1, 1, 1, 3'd0, 2'd0, 3'd0));
        chk("R10 off irq", irq, 0);

        // R4 single-word scheme
        bus_write(2'd1, cw(0, 1, 1, 0, 3'd0, 2'd0, 3'd0));
        bus_write(2'd0, 16'h1111);
        bus_read(2'd2, r);
        chk("R4 tx full at one, R9 not idle", r, sw(1, 0, 1, 0, 0, 0, 3'd0));
        bus_write(2'd0, 16'h2222);
        bus_write(2'd1, cw(1, 1, 1, 0, 3'd0, 2'd0, 3'd0));
        wait_idle();
        bus_read(2'd2, r);
        chk("R4 rx full at one", r, sw(0, 1, 0, 1, 0, 1, 3'd1));
        bus_read(2'd0, r);
        chk("R4 first word kept", r, 16'h1111);
        bus_read(2'd2, r);
        chk("R4 second write ignored", r, sw(0, 0, 1, 1, 0, 1, 3'd0));

        // R12 slave mode
        bus_write(2'd1, cw(1, 0, 1, 1, 3'd0, 2'd0, 3'd0));
        bus_write(2'd0, 16'hA5C3);
        tb_slave = 1'b1;
        slave_word(16'h3C5A, t);
        tb_slave = 1'b0;
        chk("R12 slave shifted out", t, 16'hA5C3);
        bus_read(2'd0, r);
        chk("R12 slave received", r, 16'h3C5A);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule